// File: doc/BRIEF.md
# Peripheral Register Access Unit

This block connects a small processor core to a bank of eight-bit peripheral registers. The peripherals are modelled here as plain storage. Each register can be reached through two address spaces. The first is a short I/O address, used by the dedicated I/O instructions. The second is a data-memory address, used by ordinary load and store operations. The data-memory copy of I/O register `A` sits at `A + 0x20`, so the 64 registers fill the data-memory window 0x20 to 0x5F.

The core presents an operation code, both address forms, a bit index and write data. Whole-register reads return data in the same cycle. Whole-register writes take effect at the next rising clock edge. Single-bit set and clear are performed as a read-modify-write inside one clock, so no other write can reach the register between the read and the write. Bit tests raise a combinational skip flag that tells the core whether to skip its next instruction.

A data-memory access outside the window is not claimed by this block. For such an access the block raises a miss indication and returns zero.

Top module: `ioreg_access_unit`

## Requirements
- R1: After reset every register holds 0x00, so an I/O read (op 1) of any I/O address returns 0x00.
- R2: An I/O write (op 2) stores `wdata_i` into the register at `io_addr_i` at the next rising edge. An I/O read (op 1) drives that register's value on `rdata_o` combinationally in the same cycle.
- R3: A data-memory read (op 7) or write (op 8) at address `0x20 + A` reaches the same storage as I/O address `A`, for every A from 0x00 to 0x3F.
- R4: For op 7 or op 8 with `mem_addr_i` below 0x20 or above 0x5F, `miss_o` is 1 and `rdata_o` is 0x00, and no register changes. `miss_o` is 0 for every other access.
- R5: Bit set (op 3) forces bit `bit_idx_i` of the register at `io_addr_i` to 1 and leaves the other seven bits unchanged.
- R6: Bit clear (op 4) forces bit `bit_idx_i` of the register at `io_addr_i` to 0 and leaves the other seven bits unchanged.
- R7: Skip-if-clear (op 5) drives `skip_o` to 1 exactly when bit `bit_idx_i` of the addressed register is 0. It changes no register.
- R8: Skip-if-set (op 6) drives `skip_o` to 1 exactly when bit `bit_idx_i` of the addressed register is 1. It changes no register.
- R9: `skip_o` is 0 during every operation other than op 5 and op 6. `rdata_o` is 0x00 during every operation other than op 1 and op 7.
- R10: Bit operations on the same register in consecutive cycles all take effect, because each one completes its read-modify-write in a single clock.
- R11: Op 0 and the unassigned codes 9 to 15 change no register and drive `skip_o`, `miss_o` and `rdata_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code (0 idle, 1 I/O read, 2 I/O write, 3 bit set, 4 bit clear, 5 skip-if-clear, 6 skip-if-set, 7 memory read, 8 memory write) |
| io_addr_i | input | 6 | I/O address, used by ops 1 to 6 |
| mem_addr_i | input | 16 | Data-memory address, used by ops 7 and 8 |
| bit_idx_i | input | 3 | Bit index for ops 3 to 6 |
| wdata_i | input | 8 | Write data for ops 2 and 8 |
| rdata_o | output | 8 | Read data for ops 1 and 7, otherwise zero |
| skip_o | output | 1 | Skip request from a bit test |
| miss_o | output | 1 | Data-memory access outside the register window |

## Verification
The bench sweeps every register and every bit index. It checks each set, clear and test against a byte-wide model in the bench, so a wrong bit mask or a mask that also touches neighbouring bits shows up as a corrupted read-back. It probes the window edges 0x1F, 0x20, 0x5F and 0x60, and misses far outside the window. An off-by-one in the decode would either alias a foreign address onto register 0 or 63, or drop one of them. Writes are issued to every missed address, and any that leak into storage are caught when the whole bank is read back. Back-to-back bit operations on one register show whether a split read-modify-write loses updates. The unassigned codes are driven to confirm they neither write nor raise any output.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

   typedef enum logic [3:0] {
      OP_IDLE     = 4'd0,
      OP_IO_RD    = 4'd1,
      OP_IO_WR    = 4'd2,
      OP_BIT_SET  = 4'd3,
      OP_BIT_CLR  = 4'd4,
      OP_SKIP_CLR = 4'd5,
      OP_SKIP_SET = 4'd6,
      OP_MEM_RD   = 4'd7,
      OP_MEM_WR   = 4'd8
   } op_e;

   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_FULL = 2'd1,
      WR_SET  = 2'd2,
      WR_CLR  = 2'd3
   } wr_kind_e;

endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
   import ioreg_pkg::*;
#(
   parameter int IO_AW    = 6,
   parameter int MEM_AW   = 16,
   parameter int MEM_BASE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [IO_AW-1:0]  io_addr_i,
   input  logic [MEM_AW-1:0] mem_addr_i,
   output logic [IO_AW-1:0]  idx_o,
   output wr_kind_e          wr_kind_o,
   output logic              rd_en_o,
   output logic              test_en_o,
   output logic              test_pol_o,
   output logic              miss_o
);

   localparam int NUM_REGS = 1 << IO_AW;
   localparam bit ALIGNED  = (MEM_BASE % NUM_REGS) == 0;

   logic              win_hit;
   logic [IO_AW-1:0]  win_idx;

   // Window decode: an aligned base needs only a compare of the upper bits,
   // any other base needs a subtract and a range check.
   generate
      if (ALIGNED) begin : g_aligned
         localparam logic [MEM_AW-IO_AW-1:0] BASE_TAG =
            (MEM_AW-IO_AW)'(MEM_BASE >> IO_AW);
         assign win_hit = (mem_addr_i[MEM_AW-1:IO_AW] == BASE_TAG);
         assign win_idx = mem_addr_i[IO_AW-1:0];
      end else begin : g_offset
         localparam logic [MEM_AW-1:0] WIN_LO = MEM_AW'(MEM_BASE);
         localparam logic [MEM_AW-1:0] WIN_HI = MEM_AW'(MEM_BASE + NUM_REGS);
         logic [MEM_AW-1:0] offset;
         assign offset  = mem_addr_i - WIN_LO;
         assign win_hit = (mem_addr_i >= WIN_LO) && (mem_addr_i < WIN_HI);
         assign win_idx = offset[IO_AW-1:0];
      end
   endgenerate

   always_comb begin
      idx_o      = io_addr_i;
      wr_kind_o  = WR_NONE;
      rd_en_o    = 1'b0;
      test_en_o  = 1'b0;
      test_pol_o = 1'b0;
      miss_o     = 1'b0;
      case (op_i)
         OP_IO_RD:    rd_en_o   = 1'b1;
         OP_IO_WR:    wr_kind_o = WR_FULL;
         OP_BIT_SET:  wr_kind_o = WR_SET;
         OP_BIT_CLR:  wr_kind_o = WR_CLR;
         OP_SKIP_CLR: test_en_o = 1'b1;
         OP_SKIP_SET: begin
            test_en_o  = 1'b1;
            test_pol_o = 1'b1;
         end
         OP_MEM_RD: begin
            idx_o   = win_idx;
            rd_en_o = win_hit;
            miss_o  = !win_hit;
         end
         OP_MEM_WR: begin
            idx_o     = win_idx;
            wr_kind_o = win_hit ? WR_FULL : WR_NONE;
            miss_o    = !win_hit;
         end
         default: ;
      endcase
   end

   // R4
   miss_only_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> (op_i == OP_MEM_RD || op_i == OP_MEM_WR));

   // R4
   miss_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> (wr_kind_o == WR_NONE && !rd_en_o));

   // R11
   unassigned_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd8) |-> (wr_kind_o == WR_NONE && !rd_en_o && !test_en_o && !miss_o));

endmodule

// File: rtl/ioreg_bank.sv
module ioreg_bank
   import ioreg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IO_AW  = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IO_AW-1:0]           idx_i,
   input  wr_kind_e                   wr_kind_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [$clog2(DATA_W)-1:0]  bit_idx_i,
   output logic [DATA_W-1:0]          rd_word_o
);

   localparam int NUM_REGS = 1 << IO_AW;

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_flat;
   logic [DATA_W-1:0]               bit_mask;

   assign bit_mask = DATA_W'(1) << bit_idx_i;

   // One storage slice per register; the whole read-modify-write of a bit
   // operation lands in this single always_ff.
   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic [DATA_W-1:0] q;
         logic              hit;
         assign hit = (idx_i == IO_AW'(r));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (hit) begin
               case (wr_kind_i)
                  WR_FULL: q <= wdata_i;
                  WR_SET:  q <= q | bit_mask;
                  WR_CLR:  q <= q & ~bit_mask;
                  default: q <= q;
               endcase
            end
         end
         assign regs_flat[r] = q;
      end
   endgenerate

   assign rd_word_o = regs_flat[idx_i];

   // R2
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind_i == WR_FULL) |=> (regs_flat[$past(idx_i)] == $past(wdata_i)));

   // R5
   bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind_i == WR_SET) |=> regs_flat[$past(idx_i)][$past(bit_idx_i)]);

   // R6
   bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind_i == WR_CLR) |=> !regs_flat[$past(idx_i)][$past(bit_idx_i)]);

   // R11
   no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind_i == WR_NONE) |=> $stable(regs_flat));

endmodule

// File: rtl/ioreg_bittest.sv
module ioreg_bittest #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]          word_i,
   input  logic [$clog2(DATA_W)-1:0]  bit_idx_i,
   input  logic                       test_en_i,
   input  logic                       test_pol_i,
   output logic                       skip_o
);

   logic sel_bit;

   assign sel_bit = word_i[bit_idx_i];
   assign skip_o  = test_en_i && (sel_bit == test_pol_i);

endmodule

// File: rtl/ioreg_access_unit.sv
module ioreg_access_unit
   import ioreg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int IO_AW    = 6,
   parameter int MEM_AW   = 16,
   parameter int MEM_BASE = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [3:0]                 op_i,
   input  logic [IO_AW-1:0]           io_addr_i,
   input  logic [MEM_AW-1:0]          mem_addr_i,
   input  logic [$clog2(DATA_W)-1:0]  bit_idx_i,
   input  logic [DATA_W-1:0]          wdata_i,
   output logic [DATA_W-1:0]          rdata_o,
   output logic                       skip_o,
   output logic                       miss_o
);

   localparam int NUM_REGS = 1 << IO_AW;

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 2");
      end
      if (MEM_AW <= IO_AW) begin : g_bad_mem_aw
         $error("MEM_AW must exceed IO_AW");
      end
      if (MEM_BASE < 0 || (MEM_BASE + NUM_REGS) > (1 << MEM_AW)) begin : g_bad_base
         $error("register window does not fit the data-memory space");
      end
   endgenerate

   logic [IO_AW-1:0]  idx;
   wr_kind_e          wr_kind;
   logic              rd_en;
   logic              test_en;
   logic              test_pol;
   logic [DATA_W-1:0] rd_word;

   ioreg_decode #(
      .IO_AW    (IO_AW),
      .MEM_AW   (MEM_AW),
      .MEM_BASE (MEM_BASE)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op_i),
      .io_addr_i  (io_addr_i),
      .mem_addr_i (mem_addr_i),
      .idx_o      (idx),
      .wr_kind_o  (wr_kind),
      .rd_en_o    (rd_en),
      .test_en_o  (test_en),
      .test_pol_o (test_pol),
      .miss_o     (miss_o)
   );

   ioreg_bank #(
      .DATA_W (DATA_W),
      .IO_AW  (IO_AW)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_i     (idx),
      .wr_kind_i (wr_kind),
      .wdata_i   (wdata_i),
      .bit_idx_i (bit_idx_i),
      .rd_word_o (rd_word)
   );

   ioreg_bittest #(
      .DATA_W (DATA_W)
   ) u_test (
      .word_i     (rd_word),
      .bit_idx_i  (bit_idx_i),
      .test_en_i  (test_en),
      .test_pol_i (test_pol),
      .skip_o     (skip_o)
   );

   assign rdata_o = rd_en ? rd_word : '0;

   // R9
   skip_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> (op_i == OP_SKIP_CLR || op_i == OP_SKIP_SET));

   // R9
   rdata_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o != '0) |-> (op_i == OP_IO_RD || op_i == OP_MEM_RD));

   // R4
   miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> (rdata_o == '0));

   // R7
   skip_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SKIP_CLR) |-> (skip_o == !rd_word[bit_idx_i]));

   // R8
   skip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SKIP_SET) |-> (skip_o == rd_word[bit_idx_i]));

endmodule

// File: tb/sim_ioreg_access_unit.sv
module sim_ioreg_access_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  op;
   logic [5:0]  ioa;
   logic [15:0] ma;
   logic [2:0]  bi;
   logic [7:0]  wd;
   logic [7:0]  rd;
   logic        skip;
   logic        miss;

   int          checks = 0;
   int          fails  = 0;
   logic [7:0]  model [64];
   logic [7:0]  s_rd;
   logic        s_skip;
   logic        s_miss;

   always #2 clk = ~clk;

   ioreg_access_unit u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .io_addr_i  (ioa),
      .mem_addr_i (ma),
      .bit_idx_i  (bi),
      .wdata_i    (wd),
      .rdata_o    (rd),
      .skip_o     (skip),
      .miss_o     (miss)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Apply one operation after a falling edge, sample the combinational
   // outputs 1 ns later, then let the rising edge commit it.
   task automatic drive(input logic [3:0] o, input logic [5:0] a, input logic [15:0] m,
                        input logic [2:0] b, input logic [7:0] d);
      @(negedge clk);
      op = o; ioa = a; ma = m; bi = b; wd = d;
      #1;
      s_rd = rd; s_skip = skip; s_miss = miss;
      @(posedge clk);
   endtask

   task automatic verify_bank(input string tag);
      for (int a = 0; a < 64; a++) begin
         drive(4'd1, 6'(a), 16'h0, 3'd0, 8'h0);
         chk(s_rd == model[a], tag, s_rd, model[a]);
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      op = 4'd0; ioa = '0; ma = '0; bi = '0; wd = '0;
      for (int a = 0; a < 64; a++) model[a] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: all registers read zero after reset
      verify_bank("R1 reset value");

      // R2: I/O write then I/O read, plus R9 quiet outputs during writes
      for (int a = 0; a < 64; a++) begin
         model[a] = 8'((a * 37 + 5) & 8'hFF);
         drive(4'd2, 6'(a), 16'h0, 3'd0, model[a]);
         chk(s_rd == 8'h00 && !s_skip && !s_miss, "R9 outputs idle on I/O write", s_rd, 0);
      end
      verify_bank("R2 I/O write/read");

      // R3: memory read through the aliased window
      for (int a = 0; a < 64; a++) begin
         drive(4'd7, 6'd0, 16'(a + 32), 3'd0, 8'h0);
         chk(s_rd == model[a] && !s_miss, "R3 memory alias read", s_rd, model[a]);
      end
      // R3: memory write through the window, seen at the I/O address
      for (int a = 0; a < 64; a++) begin
         model[a] = 8'(a) ^ 8'hA5;
         drive(4'd8, 6'd0, 16'(a + 32), 3'd0, model[a]);
         chk(!s_miss && s_rd == 8'h00, "R3 memory write claimed", s_miss, 0);
      end
      verify_bank("R3 memory alias write");

      // R4: misses below and above the window
      for (int m = 0; m < 160; m++) begin
         logic [15:0] addr;
         addr = (m < 32) ? 16'(m) : (m < 96) ? 16'(m + 64) : 16'(16'hFFFF - (m - 96) * 997);
         drive(4'd7, 6'd0, addr, 3'd0, 8'h0);
         chk(s_miss && s_rd == 8'h00, "R4 out-of-window read", {s_miss, s_rd}, 9'h100);
         drive(4'd8, 6'd0, addr, 3'd0, 8'hFF);
         chk(s_miss, "R4 out-of-window write miss", s_miss, 1);
      end
      verify_bank("R4 missed writes left bank unchanged");

      // R5/R6: every register, every bit
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 8; b++) begin
            drive(4'd3, 6'(a), 16'h0, 3'(b), 8'h0);
            chk(!s_skip && s_rd == 8'h00, "R9 outputs idle on bit set", s_skip, 0);
            model[a] = model[a] | (8'h01 << b);
            drive(4'd1, 6'(a), 16'h0, 3'd0, 8'h0);
            chk(s_rd == model[a], "R5 bit set", s_rd, model[a]);
            drive(4'd4, 6'(a), 16'h0, 3'(7 - b), 8'h0);
            chk(!s_skip && s_rd == 8'h00, "R9 outputs idle on bit clear", s_skip, 0);
            model[a] = model[a] & ~(8'h01 << (7 - b));
            drive(4'd1, 6'(a), 16'h0, 3'd0, 8'h0);
            chk(s_rd == model[a], "R6 bit clear", s_rd, model[a]);
         end
      end

      // R7/R8: bit tests over a patterned bank
      for (int a = 0; a < 64; a++) begin
         model[a] = 8'((a * 73 + 11) & 8'hFF);
         drive(4'd2, 6'(a), 16'h0, 3'd0, model[a]);
      end
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 8; b++) begin
            drive(4'd5, 6'(a), 16'h0, 3'(b), 8'h0);
            chk(s_skip == !model[a][b] && s_rd == 8'h00, "R7 skip-if-clear", s_skip, !model[a][b]);
            drive(4'd6, 6'(a), 16'h0, 3'(b), 8'h0);
            chk(s_skip == model[a][b] && s_rd == 8'h00, "R8 skip-if-set", s_skip, model[a][b]);
         end
      end
      verify_bank("R7 R8 tests left bank unchanged");

      // R10: back-to-back bit operations on one register
      drive(4'd2, 6'd5, 16'h0, 3'd0, 8'h00);
      for (int b = 0; b < 8; b++) drive(4'd3, 6'd5, 16'h0, 3'(b), 8'h0);
      model[5] = 8'hFF;
      drive(4'd1, 6'd5, 16'h0, 3'd0, 8'h0);
      chk(s_rd == 8'hFF, "R10 consecutive sets", s_rd, 8'hFF);
      for (int b = 0; b < 8; b += 2) drive(4'd4, 6'd5, 16'h0, 3'(b), 8'h0);
      drive(4'd3, 6'd5, 16'h0, 3'd0, 8'h0);
      model[5] = 8'hAB;
      drive(4'd1, 6'd5, 16'h0, 3'd0, 8'h0);
      chk(s_rd == 8'hAB, "R10 consecutive clears then set", s_rd, 8'hAB);

      // R11: idle and unassigned codes
      for (int c = 0; c < 16; c++) begin
         if (c >= 1 && c <= 8) continue;
         for (int a = 0; a < 64; a += 7) begin
            drive(4'(c), 6'(a), 16'(a + 32), 3'(a), 8'h5A);
            chk(s_rd == 8'h00 && !s_skip && !s_miss, "R11 unassigned code quiet",
                {s_skip, s_miss, s_rd}, 0);
         end
      end
      verify_bank("R11 unassigned codes left bank unchanged");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule